// File: doc/BRIEF.md
# Double-Precision Floating-Point Compare Unit

This block compares two IEEE-754 binary64 operands, A and B, and returns a single truth bit for a relation chosen by a 3-bit predicate code. Every predicate asks how B stands against A: "less-than" means B < A. Before any ordering is done, each operand is sorted into one of four classes: denormal, signaling NaN, quiet NaN or ordered. Denormals are rejected before anything else is looked at. Signaling NaNs always raise an invalid-operation exception. Quiet NaNs raise one only for the four ordered relational predicates.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. An operation is taken when `in_valid` and `in_ready` are both high at a clock edge. A result is consumed when `out_valid` and `out_ready` are both high at an edge. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and its exception fields stay frozen, and only a pipeline stage that is empty can take new data.

A result that raises an exception is delivered with its write-enable cleared, so it does not overwrite the destination. It still carries the exception code. Two sticky status flags, one for invalid operation and one for denormal operand, gather exceptions as results are consumed. A dedicated clear input resets them. A parameter selects a 1-cycle pipeline (fast) or a 3-cycle pipeline (area-reduced).

Top module: `fcmp64_unit`

## Requirements
- R1: Predicate codes are: 000 unordered, 001 B<A, 010 B==A, 011 B<=A, 100 B>A, 101 B!=A, 110 B>=A. For two ordered operands the result is the truth of the selected relation, and code 000 gives 0.
- R2: Ordered operands, infinities included, compare by sign and magnitude. For negatives the magnitude order is reversed, and +0 equals -0.
- R3: An operand is denormal when its exponent field (bits 62:52) is 0 and its fraction (bits 51:0) is nonzero. If either operand is denormal, this check wins over all other checks: the result is 0, the denormal flag is set, and an exception with code 00110 is raised.
- R4: A NaN has exponent field all ones and a nonzero fraction. It is signaling when fraction bit 51 is 0. If either operand is a signaling NaN, every predicate raises invalid with code 00110, and the result is 1 for codes 000 and 101 and 0 for all others.
- R5: A NaN with fraction bit 51 set is quiet. If either operand is a quiet NaN and neither is a signaling NaN, codes 000 and 101 give 1 and code 010 gives 0, with no exception.
- R6: Under the same quiet-NaN condition, codes 001, 011, 100 and 110 give 0 and raise invalid with code 00110.
- R7: Code 111 is reserved and gives 0 without an exception for operands that are not denormal and not signaling NaN.
- R8: A result with an exception has `out_exc`=1 and `out_wr_en`=0, and `out_exc_code`=00110. Without an exception, `out_wr_en`=1 and the code is 00000.
- R9: `flag_invalid` and `flag_denorm` reset to 0 and are set when a result carrying the matching exception is consumed. They hold until `flag_clr`, and a set in the same cycle as a clear wins.
- R10: With `out_ready` held high, a result appears 1 cycle after acceptance when AREA_OPT=0 and 3 cycles after when AREA_OPT=1.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_exc` and `out_exc_code` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_a | input | 64 | Operand A (binary64) |
| in_b | input | 64 | Operand B (binary64) |
| in_pred | input | 3 | Predicate code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_result | output | 1 | Comparison truth bit |
| out_wr_en | output | 1 | Result may be written (no exception) |
| out_exc | output | 1 | Exception raised by this result |
| out_exc_code | output | 5 | Exception code, 00110 or 00000 |
| flag_clr | input | 1 | Clear both sticky flags |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_denorm | output | 1 | Sticky denormal-operand flag |

## Verification
The sensitive overlap is a `flag_clr` pulse landing in the same cycle as the consumption of a result that sets a flag. The two actions pull the sticky flag in opposite directions. The bench causes this overlap in two ways: it drives random clear pulses against randomly stalled output traffic, and in a directed step it holds a signaling-NaN result at the output, then raises `out_ready` and `flag_clr` together. The reference model applies the clear first and the new event second, so the flag must read 1 afterwards. Back-pressure that stalls the output while new operations wait is compared on every clock against a queue-based model.

// File: rtl/fcmp64_pkg.sv
package fcmp64_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int DW     = 1 + EXP_W + FRAC_W;
  localparam int QBIT   = FRAC_W - 1;
  localparam logic [4:0] EXC_FP = 5'b00110;

  typedef enum logic [2:0] {
    PRED_UN  = 3'b000,
    PRED_LT  = 3'b001,
    PRED_EQ  = 3'b010,
    PRED_LE  = 3'b011,
    PRED_GT  = 3'b100,
    PRED_NE  = 3'b101,
    PRED_GE  = 3'b110,
    PRED_RSV = 3'b111
  } pred_e;

  typedef struct packed {
    logic          denorm;
    logic          snan;
    logic          qnan;
    logic          zero;
    logic          sign;
    logic [DW-2:0] mag;
  } opclass_t;

  typedef struct packed {
    logic result;
    logic exc;
    logic inv;
    logic dnz;
  } verdict_t;
endpackage

// File: rtl/fcmp64_classify.sv
module fcmp64_classify
  import fcmp64_pkg::*;
(
  input  logic [DW-1:0] word,
  output opclass_t      cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_zero, exp_ones, frac_nz, is_nan;

  always_comb begin
    exp_f    = word[DW-2 -: EXP_W];
    frac_f   = word[FRAC_W-1:0];
    exp_zero = (exp_f == '0);
    exp_ones = (exp_f == '1);
    frac_nz  = |frac_f;
    is_nan   = exp_ones & frac_nz;
    cls.denorm = exp_zero & frac_nz;
    cls.snan   = is_nan & ~frac_f[QBIT];
    cls.qnan   = is_nan & frac_f[QBIT];
    cls.zero   = exp_zero & ~frac_nz;
    cls.sign   = word[DW-1];
    cls.mag    = word[DW-2:0];
  end
endmodule

// File: rtl/fcmp64_decide.sv
module fcmp64_decide
  import fcmp64_pkg::*;
(
  input  opclass_t   ca,
  input  opclass_t   cb,
  input  logic [2:0] pred,
  output verdict_t   v
);
  logic  rel_eq, rel_b_lt, rel_b_gt, mag_b_lt;
  pred_e p;

  // Ordering of B against A for non-NaN, non-denormal operands
  always_comb begin
    mag_b_lt = (cb.mag < ca.mag);
    rel_eq   = (ca.zero & cb.zero) | ((ca.sign == cb.sign) & (ca.mag == cb.mag));
    if (rel_eq)                rel_b_lt = 1'b0;
    else if (ca.sign != cb.sign) rel_b_lt = cb.sign;
    else if (!cb.sign)         rel_b_lt = mag_b_lt;
    else                       rel_b_lt = ~mag_b_lt;
    rel_b_gt = ~rel_eq & ~rel_b_lt;
  end

  always_comb begin
    p = pred_e'(pred);
    v = '0;
    if (ca.denorm | cb.denorm) begin
      v.dnz = 1'b1;
      v.exc = 1'b1;
    end else if (ca.snan | cb.snan) begin
      v.inv    = 1'b1;
      v.exc    = 1'b1;
      v.result = (p == PRED_UN) || (p == PRED_NE);
    end else if (ca.qnan | cb.qnan) begin
      case (p)
        PRED_UN, PRED_NE: v.result = 1'b1;
        PRED_EQ, PRED_RSV: v.result = 1'b0;
        default: begin
          v.inv = 1'b1;
          v.exc = 1'b1;
        end
      endcase
    end else begin
      case (p)
        PRED_LT: v.result = rel_b_lt;
        PRED_EQ: v.result = rel_eq;
        PRED_LE: v.result = rel_b_lt | rel_eq;
        PRED_GT: v.result = rel_b_gt;
        PRED_NE: v.result = ~rel_eq;
        PRED_GE: v.result = rel_b_gt | rel_eq;
        default: v.result = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fcmp64_pipe.sv
module fcmp64_pipe #(
  parameter int DEPTH = 1,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [DEPTH-1:0] vld;
  logic [W-1:0]     dat [DEPTH];
  logic             advance;

  // Whole pipe moves when the last slot is empty or is being drained
  assign advance   = ~vld[DEPTH-1] | out_ready;
  assign in_ready  = advance;
  assign out_valid = vld[DEPTH-1];
  assign out_data  = dat[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0] <= 1'b0;
      dat[0] <= '0;
    end else if (advance) begin
      vld[0] <= in_valid;
      dat[0] <= in_data;
    end
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[s] <= 1'b0;
        dat[s] <= '0;
      end else if (advance) begin
        vld[s] <= vld[s-1];
        dat[s] <= dat[s-1];
      end
    end
  end
endmodule

// File: rtl/fcmp64_unit.sv
module fcmp64_unit
  import fcmp64_pkg::*;
#(
  parameter bit AREA_OPT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [2:0]    in_pred,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_result,
  output logic          out_wr_en,
  output logic          out_exc,
  output logic [4:0]    out_exc_code,
  input  logic          flag_clr,
  output logic          flag_invalid,
  output logic          flag_denorm
);
  localparam int LAT = AREA_OPT ? 3 : 1;
  localparam int VW  = $bits(verdict_t);

  logic [DW-1:0] opw [2];
  opclass_t      cls [2];
  verdict_t      v_now, v_out;
  logic [VW-1:0] v_out_bits;
  logic          take;

  assign opw[0] = in_a;
  assign opw[1] = in_b;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    fcmp64_classify u_cls (.word(opw[k]), .cls(cls[k]));
  end

  fcmp64_decide u_dec (
    .ca   (cls[0]),
    .cb   (cls[1]),
    .pred (in_pred),
    .v    (v_now)
  );

  fcmp64_pipe #(.DEPTH(LAT), .W(VW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (v_now),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (v_out_bits)
  );

  assign v_out        = verdict_t'(v_out_bits);
  assign out_result   = v_out.result;
  assign out_exc      = out_valid & v_out.exc;
  assign out_wr_en    = out_valid & ~v_out.exc;
  assign out_exc_code = out_exc ? EXC_FP : 5'b00000;
  assign take         = out_valid & out_ready;

  // Sticky flags: clear first, then a newly consumed event sets
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_invalid <= 1'b0;
      flag_denorm  <= 1'b0;
    end else begin
      flag_invalid <= (flag_invalid & ~flag_clr) | (take & v_out.inv);
      flag_denorm  <= (flag_denorm  & ~flag_clr) | (take & v_out.dnz);
    end
  end
endmodule

// File: rtl/fcmp64_unit_chk.sv
module fcmp64_unit_chk #(
  parameter int LAT = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_result,
  input logic       out_wr_en,
  input logic       out_exc,
  input logic [4:0] out_exc_code,
  input logic       flag_clr,
  input logic       flag_invalid,
  input logic       flag_denorm
);
  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_exc) && $stable(out_exc_code));

  // R11
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |-> out_valid && !out_ready);

  // R8
  wr_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> out_valid && !out_exc && out_exc_code == 5'b00000);

  // R9
  inv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid && !flag_clr |=> flag_invalid);

  // R9
  dnz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_denorm && !flag_clr |=> flag_denorm);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !(out_valid && out_ready && out_exc) |=> !flag_invalid && !flag_denorm);

  // R9
  inv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_invalid) |-> $past(out_valid && out_ready && out_exc));

  if (LAT == 1) begin : g_fast
    // R10
    fast_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
  end
endmodule

bind fcmp64_unit fcmp64_unit_chk #(.LAT(LAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_wr_en    (out_wr_en),
  .out_exc      (out_exc),
  .out_exc_code (out_exc_code),
  .flag_clr     (flag_clr),
  .flag_invalid (flag_invalid),
  .flag_denorm  (flag_denorm)
);

// File: tb/fcmp64_unit_test.sv
module fcmp64_unit_test;
  localparam bit AREA_OPT = 1'b0;
  localparam int LAT = AREA_OPT ? 3 : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [2:0] in_pred = '0;
  logic out_valid, out_ready = 1'b1, out_result, out_wr_en, out_exc;
  logic [4:0] out_exc_code;
  logic flag_clr = 1'b0, flag_invalid, flag_denorm;

  always #10 clk = ~clk;

  fcmp64_unit #(.AREA_OPT(AREA_OPT)) uut (.*);

  int n_checks = 0, n_fail = 0, cyc = 0, last_stall = -1;
  logic [3:0] q_exp [$];
  string      q_tag [$];
  int         q_cyc [$];
  logic m_inv = 1'b0, m_dnz = 1'b0;
  logic hold_prev = 1'b0, p_res, p_exc;
  logic [4:0] p_code;
  logic [63:0] vals [14];

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic is_dn(input logic [63:0] x);
    return x[62:52] == 11'd0 && x[51:0] != 52'd0;
  endfunction
  function automatic logic is_nan(input logic [63:0] x);
    return x[62:52] == 11'h7ff && x[51:0] != 52'd0;
  endfunction

  // Returns {result, exc, inv, dnz}
  function automatic logic [3:0] expect_fn(input logic [63:0] a, b, input logic [2:0] op, output string tag);
    real ra, rb;
    logic r;
    if (is_dn(a) || is_dn(b)) begin tag = "R3"; return 4'b0101; end
    if ((is_nan(a) && !a[51]) || (is_nan(b) && !b[51])) begin
      tag = "R4"; return {(op == 3'd0 || op == 3'd5), 3'b110};
    end
    if (is_nan(a) || is_nan(b)) begin
      if (op == 3'd0 || op == 3'd5) begin tag = "R5"; return 4'b1000; end
      if (op == 3'd2) begin tag = "R5"; return 4'b0000; end
      if (op == 3'd7) begin tag = "R7"; return 4'b0000; end
      tag = "R6"; return 4'b0110;
    end
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    case (op)
      3'd1: r = rb < ra;
      3'd2: r = rb == ra;
      3'd3: r = rb <= ra;
      3'd4: r = rb > ra;
      3'd5: r = rb != ra;
      3'd6: r = rb >= ra;
      default: r = 1'b0;
    endcase
    tag = (op == 3'd7) ? "R7" : ((a[63] | b[63] | a[62:52] == 11'd0 | a[62:52] == 11'h7ff) ? "R2" : "R1");
    return {r, 3'b000};
  endfunction

  task automatic step(input logic v, input logic [63:0] a, b, input logic [2:0] op,
                      input logic ordy, input logic clr);
    logic pop_inv, pop_dnz;
    logic [3:0] e;
    string tg;
    in_valid = v; in_a = a; in_b = b; in_pred = op; out_ready = ordy; flag_clr = clr;
    #1;
    pop_inv = 1'b0; pop_dnz = 1'b0;
    chk(flag_invalid == m_inv, "R9 invalid flag", 64'(flag_invalid), 64'(m_inv));
    chk(flag_denorm == m_dnz, "R9 denorm flag", 64'(flag_denorm), 64'(m_dnz));
    chk(in_ready == (!out_valid || out_ready), "R11 in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
    if (hold_prev)
      chk(out_valid && out_result == p_res && out_exc == p_exc && out_exc_code == p_code,
          "R11 held output", {out_valid, out_result, out_exc, out_exc_code}, {1'b1, p_res, p_exc, p_code});
    if (out_valid && out_ready) begin
      if (q_exp.size() == 0) chk(1'b0, "R11 spurious output", 64'd1, 64'd0);
      else begin
        int ic;
        e = q_exp.pop_front(); tg = q_tag.pop_front(); ic = q_cyc.pop_front();
        chk(out_result == e[3], tg, 64'(out_result), 64'(e[3]));
        chk(out_exc == e[2] && out_wr_en == !e[2] && out_exc_code == (e[2] ? 5'b00110 : 5'b00000),
            "R8 exception fields", {out_exc, out_wr_en, out_exc_code}, {e[2], !e[2], (e[2] ? 5'b00110 : 5'b00000)});
        if (ic > last_stall) chk(cyc - ic == LAT, "R10 latency", 64'(cyc - ic), 64'(LAT));
        pop_inv = e[1]; pop_dnz = e[0];
      end
    end
    if (in_valid && in_ready) begin
      q_exp.push_back(expect_fn(a, b, op, tg)); q_tag.push_back(tg); q_cyc.push_back(cyc);
    end
    if (!ordy) last_stall = cyc;
    m_inv = (m_inv & !clr) | pop_inv;
    m_dnz = (m_dnz & !clr) | pop_dnz;
    hold_prev = out_valid && !out_ready;
    p_res = out_result; p_exc = out_exc; p_code = out_exc_code;
    @(negedge clk);
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && (q_exp.size() != 0); i++) step(1'b0, '0, '0, 3'd0, 1'b1, 1'b0);
    step(1'b0, '0, '0, 3'd0, 1'b1, 1'b0);
  endtask

  initial begin
    vals[0] = 64'h3FF0000000000000; vals[1] = 64'h4000000000000000;
    vals[2] = 64'hBFF0000000000000; vals[3] = 64'hC000000000000000;
    vals[4] = 64'h0000000000000000; vals[5] = 64'h8000000000000000;
    vals[6] = 64'h7FF0000000000000; vals[7] = 64'hFFF0000000000000;
    vals[8] = 64'h7FF8000000000000; vals[9] = 64'h7FF0000000000001;
    vals[10] = 64'h0000000000000001; vals[11] = 64'h800FFFFFFFFFFFFF;
    vals[12] = 64'h7FEFFFFFFFFFFFFF; vals[13] = 64'h3FF0000000000001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R11 reset out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R11 reset in_ready", 64'(in_ready), 64'd1);
    chk(!flag_invalid && !flag_denorm, "R9 reset flags", {flag_invalid, flag_denorm}, 64'd0);
    @(negedge clk);
    // Every pair under every predicate, output always ready
    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 14; j++)
        for (int op = 0; op < 8; op++)
          step(1'b1, vals[i], vals[j], 3'(op), 1'b1, 1'b0);
    drain();
    // Random traffic, stalls and clear pulses
    for (int n = 0; n < 3000; n++)
      step(($urandom_range(0, 3) != 0), vals[$urandom_range(0, 13)], vals[$urandom_range(0, 13)],
           3'($urandom_range(0, 7)), ($urandom_range(0, 2) != 0), ($urandom_range(0, 7) == 0));
    drain();
    // Directed: clear and a flag-setting consumption in the same cycle (R9)
    step(1'b0, '0, '0, 3'd0, 1'b1, 1'b1);
    step(1'b1, vals[0], vals[9], 3'd2, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, '0, '0, 3'd0, 1'b0, 1'b0);
    step(1'b0, '0, '0, 3'd0, 1'b1, 1'b1);
    #1;
    chk(flag_invalid == 1'b1, "R9 set wins over clear", 64'(flag_invalid), 64'd1);
    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule